// File: doc/BRIEF.md
# Memory Calibration Pattern Checker

This block exercises a 32-bit memory through a request port and reports which data bit positions fail. A single start pulse launches a fixed suite of six test patterns. For each pattern the block writes every word to addresses equal to the word index. It then reads the words back in the same order and compares each returned word with the word that was written. The differences are combined into a 32-bit failure mask, and a pass flag summarises the run.

Three checking modes are available. Full mode runs the whole suite and ORs every difference into the mask. Quick mode stops at the first word that differs and reports that single difference. Any-good mode also accumulates the mask, but it declares failure only when every bit position has failed somewhere. In quick and any-good modes, reads that are still in flight when the block stops are allowed to return and are discarded. The memory side uses a valid/ready request channel and an in-order read-data strobe, so the block can sit in front of any controller that keeps read responses in order.

Top module: `cal_pattern_checker`

## Requirements
- R1: While reset is asserted and after its release, busy, done, pass and req_valid are 0 and fail_mask is 0.
- R2: Patterns are written in the order 0..5, and each word goes to the address equal to its index. Pattern 0 is 32 words that alternate between 0xAAAAAAAA (even index) and 0x55555555 (odd index). Pattern 1 is 8 words that are all zero except index 2, which is 0xFFFFFFFF. Patterns 2, 3, 4 and 5 are 256 words each, with value index<<0, index<<8, index<<16 and index<<24.
- R3: Every word of a pattern is written before the first read of that pattern. Reads go to addresses 0 up to length-1 in ascending order, and the N-th read response is compared with word N.
- R4: In full mode (mode 0, and also mode 3), all 1064 words are written and read back. fail_mask is the OR of (read XOR expected) over every word, and pass is 1 exactly when fail_mask is 0.
- R5: In quick mode (mode 1), checking stops at the first nonzero difference. fail_mask equals that difference, pass is 0, and no later pattern is written. If no word differs, the result is the same as in full mode.
- R6: In any-good mode (mode 2), checking stops as soon as the accumulated mask is all ones, with pass 0 and fail_mask 0xFFFFFFFF. Otherwise the whole suite runs, fail_mask is the accumulated mask and pass is 1.
- R7: done is high for exactly one cycle at the end of a run. busy is high from the cycle after an accepted start up to and including the done cycle.
- R8: fail_mask and pass hold their values from done until the next accepted start. A start pulse while busy is ignored, and mode is sampled only on an accepted start.
- R9: After an early stop, no further requests are issued. Responses to reads already accepted are absorbed without changing fail_mask, and done is raised only after all of them have returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted while idle |
| mode | input | 2 | 0 full, 1 quick, 2 any-good, 3 full |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Verdict of the last run |
| fail_mask | output | 32 | Failing bit positions of the last run |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | ADDR_W | Word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data strobe, in request order |
| rsp_rdata | input | 32 | Read data |

## Verification
A wrong pattern or word counter shows up at once as a write whose address or data disagrees with the word index, or as a pattern that starts reading before it is fully written. This is visible on the request port in the cycle it happens. A broken response counter or a broken mask merge shows up as a wrong fail_mask or pass at done. Losing track of in-flight reads after an early stop shows up in two ways: done arrives while responses are still queued in the memory model, or fail_mask is altered by stale data. Stuck-at and single-address fault injection make quick and any-good stops land early, late, or not at all.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_PAT  = 6;
  localparam int CHK_LEN  = 32;
  localparam int STB_LEN  = 8;
  localparam int STB_POS  = 2;
  localparam int RAMP_LEN = 256;
  localparam int MAX_LEN  = RAMP_LEN;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);
  localparam int IDX_W    = $clog2(MAX_LEN);
  localparam int PAT_W    = $clog2(NUM_PAT);

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_QUICK = 2'd1,
    MODE_ANY   = 2'd2,
    MODE_FULL2 = 2'd3
  } chk_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_DRAIN, ST_DONE
  } seq_state_e;

  function automatic logic [CNT_W-1:0] pat_last(input logic [PAT_W-1:0] p);
    case (p)
      PAT_W'(0): pat_last = CNT_W'(CHK_LEN - 1);
      PAT_W'(1): pat_last = CNT_W'(STB_LEN - 1);
      default:   pat_last = CNT_W'(RAMP_LEN - 1);
    endcase
  endfunction
endpackage

// File: rtl/cpc_pattern_rom.sv
module cpc_pattern_rom
  import cpc_pkg::*;
(
  input  logic [PAT_W-1:0]  pat_sel,
  input  logic [CNT_W-1:0]  word_idx,
  output logic [WORD_W-1:0] word
);
  logic [1:0] lane;

  assign lane = pat_sel[1:0] ^ 2'b10;

  always_comb begin
    word = '0;
    case (pat_sel)
      PAT_W'(0): word = word_idx[0] ? {(WORD_W/2){2'b01}} : {(WORD_W/2){2'b10}};
      PAT_W'(1): word = (word_idx == CNT_W'(STB_POS)) ? '1 : '0;
      PAT_W'(2), PAT_W'(3), PAT_W'(4), PAT_W'(5):
        word = WORD_W'(word_idx[IDX_W-1:0]) << {lane, 3'b000};
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/cpc_sequencer.sv
module cpc_sequencer
  import cpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             stop_now,
  output logic             req_valid,
  output logic             req_write,
  output logic [CNT_W-1:0] wr_idx,
  output logic [CNT_W-1:0] rd_idx,
  output logic [PAT_W-1:0] pat_sel,
  output logic             run_start,
  output logic             rsp_take,
  output logic             settle,
  output logic             busy,
  output logic             done
);
  seq_state_e       st_q, st_d;
  logic [PAT_W-1:0] pat_q, pat_d;
  logic [CNT_W-1:0] wc_q, wc_d, rc_q, rc_d, last;
  logic             hs, rd_left;

  assign last      = pat_last(pat_q);
  assign rd_left   = (wc_q != last + CNT_W'(1));
  assign req_valid = (st_q == ST_WRITE) || ((st_q == ST_READ) && rd_left);
  assign req_write = (st_q == ST_WRITE);
  assign hs        = req_valid && req_ready;
  assign run_start = (st_q == ST_IDLE) && start;
  assign rsp_take  = (st_q == ST_READ) && rsp_valid;
  assign settle    = (st_q == ST_DRAIN) &&
                     ((rc_q == wc_q) || (rsp_valid && (rc_q + CNT_W'(1) == wc_q)));
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign wr_idx    = wc_q;
  assign rd_idx    = rc_q;
  assign pat_sel   = pat_q;

  always_comb begin
    st_d  = st_q;
    pat_d = pat_q;
    wc_d  = wc_q;
    rc_d  = rc_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_WRITE;
        pat_d = '0;
        wc_d  = '0;
        rc_d  = '0;
      end
      ST_WRITE: if (hs) begin
        if (wc_q == last) begin
          wc_d = '0;
          st_d = ST_READ;
        end else begin
          wc_d = wc_q + CNT_W'(1);
        end
      end
      ST_READ: begin
        if (hs) wc_d = wc_q + CNT_W'(1);
        if (rsp_valid) begin
          rc_d = rc_q + CNT_W'(1);
          if (stop_now) begin
            st_d = ST_DRAIN;
          end else if (rc_q == last) begin
            if (pat_q == PAT_W'(NUM_PAT - 1)) begin
              st_d = ST_DRAIN;
            end else begin
              pat_d = pat_q + PAT_W'(1);
              st_d  = ST_WRITE;
              wc_d  = '0;
              rc_d  = '0;
            end
          end
        end
      end
      ST_DRAIN: begin
        if (rsp_valid) rc_d = rc_q + CNT_W'(1);
        if (settle) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pat_q <= '0;
      wc_q  <= '0;
      rc_q  <= '0;
    end else begin
      st_q  <= st_d;
      pat_q <= pat_d;
      wc_q  <= wc_d;
      rc_q  <= rc_d;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rsp_expected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((st_q == ST_READ) || (st_q == ST_DRAIN)) && (rc_q != wc_q)));
  assert_write_before_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> (rc_q <= wc_q));
  assert_no_req_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |-> !req_valid);
endmodule

// File: rtl/cpc_mask_acc.sv
module cpc_mask_acc
  import cpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic              rsp_take,
  input  logic              settle,
  input  logic              busy,
  input  logic [1:0]        mode_in,
  input  logic [WORD_W-1:0] rsp_rdata,
  input  logic [WORD_W-1:0] exp_word,
  output logic              stop_now,
  output logic [WORD_W-1:0] fail_mask,
  output logic              pass
);
  chk_mode_e         mode_q, mode_d;
  logic [WORD_W-1:0] mask_q, mask_d, diff, merged;
  logic              pass_q, pass_d, quick_hit, any_hit;

  assign diff      = rsp_rdata ^ exp_word;
  assign merged    = mask_q | diff;
  assign quick_hit = (mode_q == MODE_QUICK) && (diff != '0);
  assign any_hit   = (mode_q == MODE_ANY) && (&merged);
  assign stop_now  = rsp_take && (quick_hit || any_hit);
  assign fail_mask = mask_q;
  assign pass      = pass_q;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    pass_d = pass_q;
    if (run_start) begin
      mode_d = chk_mode_e'(mode_in);
      mask_d = '0;
      pass_d = 1'b0;
    end else begin
      if (rsp_take) mask_d = quick_hit ? diff : merged;
      if (settle)   pass_d = (mode_q == MODE_ANY) ? ~(&mask_q) : (mask_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_FULL;
      mask_q <= '0;
      pass_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      pass_q <= pass_d;
    end
  end

  assert_mask_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((fail_mask | $past(fail_mask)) == fail_mask));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !run_start) |=> ($stable(fail_mask) && $stable(pass)));
  assert_quick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_QUICK && fail_mask != '0) |-> !rsp_take);
endmodule

// File: rtl/cal_pattern_checker.sv
module cal_pattern_checker
  import cpc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [WORD_W-1:0] fail_mask,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_rdata
);
  logic [CNT_W-1:0]  wr_idx, rd_idx;
  logic [PAT_W-1:0]  pat_sel;
  logic [WORD_W-1:0] exp_word;
  logic              run_start, rsp_take, settle, stop_now;

  cpc_sequencer i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .stop_now(stop_now), .req_valid(req_valid),
    .req_write(req_write), .wr_idx(wr_idx), .rd_idx(rd_idx), .pat_sel(pat_sel),
    .run_start(run_start), .rsp_take(rsp_take), .settle(settle),
    .busy(busy), .done(done)
  );

  cpc_pattern_rom i_wr_rom (.pat_sel(pat_sel), .word_idx(wr_idx), .word(req_wdata));
  cpc_pattern_rom i_rd_rom (.pat_sel(pat_sel), .word_idx(rd_idx), .word(exp_word));

  assign req_addr = ADDR_W'(wr_idx[IDX_W-1:0]);

  cpc_mask_acc i_acc (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .rsp_take(rsp_take),
    .settle(settle), .busy(busy), .mode_in(mode), .rsp_rdata(rsp_rdata),
    .exp_word(exp_word), .stop_now(stop_now), .fail_mask(fail_mask), .pass(pass)
  );
endmodule

// File: tb/test_cal_pattern_checker.sv
module test_cal_pattern_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        busy, done, pass, req_valid, req_write;
  logic [31:0] fail_mask, req_wdata;
  logic [7:0]  req_addr;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;

  int checks = 0, failures = 0;
  logic [31:0] mem [256];
  logic [31:0] rq [$];
  logic [31:0] s0 = '0, s1 = '0, fmask = '0;
  int fa = -1;
  int cur_p, wr_i, rd_i, wr_cnt, trk_err;

  always #4 clk = ~clk;

  cal_pattern_checker i_cal_pattern_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy), .done(done),
    .pass(pass), .fail_mask(fail_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic int tlen(input int p);
    return (p == 0) ? 32 : (p == 1) ? 8 : 256;
  endfunction

  function automatic logic [31:0] tword(input int p, input int i);
    if (p == 0) return (i % 2 == 1) ? 32'h5555_5555 : 32'hAAAA_AAAA;
    if (p == 1) return (i == 2) ? 32'hFFFF_FFFF : 32'h0;
    return 32'(i) << (8 * (p - 2));
  endfunction

  function automatic logic [31:0] faulty(input logic [31:0] w, input int a);
    logic [31:0] r;
    r = (w & ~s0) | s1;
    if (a == fa) r = r ^ fmask;
    return r;
  endfunction

  task automatic model(input logic [1:0] m, output logic [31:0] em, output logic ep,
                       output int enw);
    logic [31:0] acc, d;
    int tot;
    acc = '0; tot = 0;
    for (int p = 0; p < 6; p++) begin
      tot += tlen(p);
      for (int i = 0; i < tlen(p); i++) begin
        d = tword(p, i) ^ faulty(tword(p, i), i);
        if (m == 2'd1 && d != 0) begin em = d; ep = 1'b0; enw = tot; return; end
        acc |= d;
        if (m == 2'd2 && &acc) begin em = acc; ep = 1'b0; enw = tot; return; end
      end
    end
    em = acc; enw = tot;
    ep = (m == 2'd2) ? ~(&acc) : (acc == 0);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory: random ready, in-order responses with random delay
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0;
      rsp_valid = 1'b0;
    end else begin
      rsp_valid = 1'b0;
      if (rq.size() > 0 && ($urandom % 3) != 0) begin
        rsp_rdata = rq.pop_front();
        rsp_valid = 1'b1;
      end
      req_ready = ($urandom % 4) != 0;
      if (req_valid && req_ready) begin
        if (req_write) begin
          if (rd_i > 0) begin cur_p++; wr_i = 0; rd_i = 0; end
          if (req_addr != 8'(wr_i) || req_wdata != tword(cur_p, wr_i)) trk_err++;
          mem[req_addr] = req_wdata;
          wr_i++; wr_cnt++;
        end else begin
          if (req_addr != 8'(rd_i) || wr_i != tlen(cur_p)) trk_err++;
          rq.push_back(faulty(mem[req_addr], int'(req_addr)));
          rd_i++;
        end
      end
    end
  end

  task automatic run(input logic [1:0] m, input logic [31:0] a0, input logic [31:0] a1,
                     input int fadr, input logic [31:0] fm, input bit poke, input string rq_tag);
    logic [31:0] em, hm;
    logic ep, hp;
    int enw, cyc;
    s0 = a0; s1 = a1; fa = fadr; fmask = fm;
    model(m, em, ep, enw);
    cur_p = 0; wr_i = 0; rd_i = 0; wr_cnt = 0; trk_err = 0;
    @(negedge clk); mode = m; start = 1'b1;
    @(negedge clk); start = 1'b0; mode = ~m;
    check(busy == 1'b1, "R7 busy after start", 32'(busy), 1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 200) begin start = 1'b1; mode = 2'd1; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    if (!done) begin
      check(1'b0, {rq_tag, " watchdog"}, cyc, 20000);
      return;
    end
    check(fail_mask == em, {rq_tag, " fail_mask"}, fail_mask, em);
    check(pass == ep, {rq_tag, " pass"}, 32'(pass), 32'(ep));
    check(wr_cnt == enw, {rq_tag, " writes issued R5"}, wr_cnt, enw);
    check(trk_err == 0, "R2 R3 write/read order and data", trk_err, 0);
    check(rq.size() == 0, "R9 no reads outstanding at done", rq.size(), 0);
    hm = fail_mask; hp = pass;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 done one cycle", {done, busy}, 0);
    repeat (4) @(negedge clk);
    check(fail_mask == hm && pass == hp, "R8 results hold", fail_mask, hm);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 190000) begin
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", wd, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    check(!busy && !done && !pass && !req_valid && fail_mask == 0, "R1 in reset",
          fail_mask, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !pass && !req_valid && fail_mask == 0, "R1 after reset",
          fail_mask, 0);

    run(2'd0, 32'h0, 32'h0, -1, 32'h0, 1'b0, "R4 full clean");
    run(2'd0, 32'h0, 32'h0000_0001, -1, 32'h0, 1'b0, "R4 full stuck1");
    run(2'd3, 32'h0100_0000, 32'h0, 77, 32'h0000_8000, 1'b0, "R4 mode3");
    run(2'd0, 32'h0, 32'h0, 200, 32'h0040_0000, 1'b0, "R4 full one address");
    run(2'd1, 32'h0, 32'h0, -1, 32'h0, 1'b0, "R5 quick clean");
    run(2'd1, 32'h0000_0002, 32'h0, -1, 32'h0, 1'b0, "R5 quick word0");
    run(2'd1, 32'h0, 32'h8000_0000, -1, 32'h0, 1'b0, "R5 quick word1");
    run(2'd1, 32'h0, 32'h0, 100, 32'h0000_0010, 1'b0, "R5 quick late");
    run(2'd2, 32'hFFFF_FFFF, 32'h0, -1, 32'h0, 1'b0, "R6 anygood all fail");
    run(2'd2, 32'h0, 32'h0000_FFFF, -1, 32'h0, 1'b0, "R6 anygood partial");
    run(2'd2, 32'hFFFF_0000, 32'h0000_FFFF, -1, 32'h0, 1'b0, "R6 anygood split");
    run(2'd0, 32'h0, 32'h0010_0000, -1, 32'h0, 1'b1, "R8 start ignored");
    for (int k = 0; k < 6; k++) begin
      logic [31:0] r0, r1;
      logic [1:0] rm;
      r0 = $urandom & $urandom & $urandom;
      r1 = $urandom & $urandom & $urandom & ~r0;
      rm = 2'($urandom % 4);
      run(rm, r0, r1, int'($urandom % 256), $urandom & $urandom, 1'b0, "R4 R5 R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule